// File: doc/BRIEF.md
# Prescaled Hybrid Up-Counter

This block is a free-running binary up-counter for fabrics where a wide, fast carry chain is expensive or missing. The count is split into two fields. A narrow low field of `LOW_W` bits is the prescaler: it advances on every enabled clock. A wide high field of `HIGH_W` bits is a plain ripple-carry incrementer that steps only when the prescaler rolls over.

The prescaler keeps a registered terminal-count flag that is set while its field holds all ones. The high field's step strobe is this flag gated by the enable, a single gate behind a flop. The high field's own incrementer reads nothing but the high field's own register, which can change at most once every `2^LOW_W` cycles. Its ripple chain therefore has `2^LOW_W` clock periods to settle; eight periods with the default three-bit prescaler. The multicycle constraint for that path is left to the integrator.

The low field is built as a direct synchronous counter, so no deskew stage is needed. The output `{high, low}` is straight binary on every cycle. The counter has no load path, because the prescaler scheme cannot accept an arbitrary starting value without extra logic. Reset is synchronous and active low.

Top module: `prescaled_counter`

## Requirements
- R1: A rising clock edge with `rst_n` low sets `count` to zero.
- R2: An edge with `rst_n` high and `cnt_en` high sets `count` to its previous value plus one, modulo 2^(LOW_W+HIGH_W).
- R3: An edge with `rst_n` high and `cnt_en` low leaves `count` unchanged.
- R4: When the low field `count[LOW_W-1:0]` is all ones and `cnt_en` is high, the same edge clears the low field and increments the high field `count[LOW_W+HIGH_W-1:LOW_W]`, with no cycle of skew between the two fields.
- R5: The high field changes only on an edge where the low field was all ones and `cnt_en` was high, or on a reset edge.
- R6: With `count` all ones and `cnt_en` high, the next edge makes `count` zero.
- R7: Reset takes priority over `cnt_en`: an edge with both `rst_n` low and `cnt_en` high still gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears the whole count |
| cnt_en | input | 1 | Count enable; when high the count advances by one |
| count | output | LOW_W+HIGH_W | Current count in straight binary; the low field is bits LOW_W-1:0 |

## Verification
A stale or mistimed prescaler flag shows at the ports on the wrap edge itself. The high field would step one cycle late, so `count` would read the low field at zero beside the old high value. It might also step twice, or step when the enable was low. Any of these is visible in the cycle after the faulty edge. A wrong ripple bit in the high field shows at the first high-field step that sends a carry through that bit, at most `2^(LOW_W+HIGH_W)` enabled cycles after reset. Runs with random enable gaps, long idle stretches, a continuous run across the full wrap and a reset while enabled let a cycle-exact reference count expose each of these cases.

// File: rtl/pcnt_pkg.sv
// Package: shared defaults for the prescaled counter.
// Assumes: both field widths are at least one bit.
package pcnt_pkg;
    parameter int unsigned PCNT_LOW_W_DEF  = 3;
    parameter int unsigned PCNT_HIGH_W_DEF = 7;
endpackage

// File: rtl/pcnt_prescaler.sv
// Module: pcnt_prescaler
// Fast low field of the counter. Each bit toggles when enable is high and all
// lower bits are ones (a short AND chain, LOW_W deep). A registered flag mirrors
// "low field is all ones"; the outgoing step strobe is that flag ANDed with the
// enable, so downstream logic sees one gate after a flop.
// Assumes: LOW_W >= 1, synchronous active-low reset.
module pcnt_prescaler #(
    parameter int unsigned LOW_W = pcnt_pkg::PCNT_LOW_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [LOW_W-1:0] low_o,
    output logic             step_o
);
    localparam logic [LOW_W-1:0] LOW_ONE = LOW_W'(1);

    logic [LOW_W-1:0] low_q;
    logic [LOW_W-1:0] low_d;
    logic [LOW_W:0]   tog_chain;
    logic             full_q;

    assign tog_chain[0] = en_i;

    // Per-bit toggle logic: bit i flips when enabled and all lower bits are one.
    genvar gi;
    generate
        for (gi = 0; gi < LOW_W; gi++) begin : g_bit
            assign low_d[gi]         = low_q[gi] ^ tog_chain[gi];
            assign tog_chain[gi + 1] = tog_chain[gi] & low_q[gi];
        end
    endgenerate

    // Low field register and its registered all-ones flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            full_q <= 1'b0;
        end else begin
            low_q  <= low_d;
            full_q <= &low_d;
        end
    end

    // Step strobe for the high field: flag gated by enable.
    always_comb begin
        step_o = full_q & en_i;
    end

    assign low_o = low_q;

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> low_q == $past(low_q) + LOW_ONE);                 // R2
    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(low_q));                                 // R3
    AST_STROBE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_o == tog_chain[LOW_W]);                               // R4
endmodule

// File: rtl/pcnt_ripple_section.sv
// Module: pcnt_ripple_section
// Slow high field of the counter. Its +1 value is formed by a plain ripple
// chain of half adders that reads only this field's own register. The field
// changes at most once every 2^LOW_W cycles, so the chain is a multicycle path.
// Assumes: HIGH_W >= 1, step_i is high for single cycles only, synchronous
// active-low reset.
module pcnt_ripple_section #(
    parameter int unsigned HIGH_W = pcnt_pkg::PCNT_HIGH_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [HIGH_W-1:0] high_o
);
    localparam logic [HIGH_W-1:0] HIGH_ONE = HIGH_W'(1);

    logic [HIGH_W-1:0] high_q;
    logic [HIGH_W-1:0] inc_sum;
    logic [HIGH_W-1:0] rip_c;

    assign rip_c[0] = 1'b1;

    // Ripple chain: one half adder per bit, carry passed to the next bit.
    genvar gi;
    generate
        for (gi = 0; gi < HIGH_W; gi++) begin : g_cell
            assign inc_sum[gi] = high_q[gi] ^ rip_c[gi];
            if (gi < HIGH_W - 1) begin : g_carry
                assign rip_c[gi + 1] = high_q[gi] & rip_c[gi];
            end
        end
    endgenerate

    // High field register: loads the settled sum on a step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= '0;
        end else if (step_i) begin
            high_q <= inc_sum;
        end
    end

    assign high_o = high_q;

    AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(high_q));                              // R5
    AST_HIGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> high_q == $past(high_q) + HIGH_ONE);            // R4
endmodule

// File: rtl/prescaled_counter.sv
// Module: prescaled_counter (top)
// Non-loadable up-counter: a fast prescaler for the low LOW_W bits and a
// ripple-carry high field of HIGH_W bits stepped by the prescaler's strobe.
// The output is straight binary every cycle; there is no deskew stage.
// Assumes: the path from the high field register through its ripple chain
// is constrained as a 2^LOW_W cycle multicycle path by the integrator.
module prescaled_counter #(
    parameter int unsigned LOW_W  = pcnt_pkg::PCNT_LOW_W_DEF,
    parameter int unsigned HIGH_W = pcnt_pkg::PCNT_HIGH_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    output logic [LOW_W+HIGH_W-1:0] count
);
    localparam int unsigned TOTAL_W = LOW_W + HIGH_W;

    logic [LOW_W-1:0]  low_val;
    logic [HIGH_W-1:0] high_val;
    logic              high_step;

    pcnt_prescaler #(.LOW_W(LOW_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cnt_en),
        .low_o  (low_val),
        .step_o (high_step)
    );

    pcnt_ripple_section #(.HIGH_W(HIGH_W)) u_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (high_step),
        .high_o (high_val)
    );

    // Output assembly: fields concatenated, no extra logic.
    assign count = {high_val, low_val};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> count == '0);                                   // R1 R7
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && (&count)) |=> count == '0);                     // R6
    AST_WRAP_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && (&count[LOW_W-1:0]))
        |=> count[TOTAL_W-1:LOW_W] == $past(count[TOTAL_W-1:LOW_W]) + 1'b1); // R4
endmodule

// File: tb/prescaled_counter_test.sv
module prescaled_counter_test;
    localparam int LW    = 3;
    localparam int HW    = 7;
    localparam int TW    = LW + HW;
    localparam int MODV  = 1 << TW;
    localparam int LMAX  = (1 << LW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic [TW-1:0] count;

    int ref_cnt = 0;
    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    prescaled_counter #(.LOW_W(LW), .HIGH_W(HW)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .count  (count)
    );

    always #5 clk = ~clk;

    // One cycle: drive at negedge, let the edge pass, compare at next negedge.
    task automatic step(input bit rn, input bit en);
        int    prev;
        string tag;
        prev   = ref_cnt;
        rst_n  = rn;
        cnt_en = en;
        @(posedge clk);
        if (!rn)                   ref_cnt = 0;
        else if (en)               ref_cnt = (ref_cnt + 1) % MODV;
        if (!rn && en)                  tag = "R7";
        else if (!rn)                   tag = "R1";
        else if (en && prev == MODV-1)  tag = "R6";
        else if (en && (prev & LMAX) == LMAX) tag = "R4";
        else if (en)                    tag = "R2";
        else                            tag = "R3";
        @(negedge clk);
        vectors++;
        if (int'(count) != ref_cnt) begin
            misses++;
            $display("FAIL %s count actual %0d expected %0d", tag, count, ref_cnt);
        end
        vectors++;
        if ((int'(count) >> LW) != (ref_cnt >> LW)) begin
            misses++;
            $display("FAIL R5 high field actual %0d expected %0d",
                     int'(count) >> LW, ref_cnt >> LW);
        end
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0);                       // R1 reset state
        step(1'b0, 1'b1);                       // R7 reset beats enable
        for (int i = 0; i < 4500; i++)          // R2 R3 R4 random gaps
            step(1'b1, ($urandom % 4) != 0);
        for (int i = 0; i < 20; i++)            // R3 long idle
            step(1'b1, 1'b0);
        for (int i = 0; i < MODV + 40; i++)     // R6 full wrap, continuous
            step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++)             // R7 reset while enabled
            step(1'b0, 1'b1);
        for (int i = 0; i < 3000; i++)          // R2 R3 R4 R5 sparse enable
            step(1'b1, ($urandom % 3) == 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule